// File: doc/BRIEF.md
# Cascadable Programmable Interrupt Controller

This block gathers eight interrupt request lines, ranks them by fixed priority and hands the processor one vector at a time. Software reaches it through a byte-wide register port with two addresses: a command address and a data address. A short write sequence initialises it. A command write with bit 4 set opens the sequence. The data writes that follow load, in turn, the vector base, then the cascade word, then the mode word. After that, data writes set the line mask.

Requests are rising-edge sensitive. They are synchronised and then held in a pending register until a line is acknowledged. A pending line that is unmasked and outranks every line already in service raises `irq_o`. An acknowledge strobe moves the winning line into the in-service register and queues its vector on a valid/ready output. If a request disappears before the acknowledge, the block answers with the line-7 vector and leaves the in-service register untouched, so software can recognise the event as spurious.

Two copies can be chained. A master whose winning line has a slave attached does not issue a vector itself. Instead it publishes that line number on its cascade pins, and the slave with the matching identity supplies the vector. The vector output holds its value until `vec_ready` is seen. While a vector is waiting, further acknowledges are ignored. That is the only form of back-pressure.

Top module: `pic_ctrl`

## Requirements
- R1: After reset `irq_o` and `vec_valid` are low, a data read returns 0xFF, a command read returns 0x00, and `irq_o` stays low until the initialisation sequence completes.
- R2: A command write with bit 4 set restarts initialisation. It clears the mask, in-service and pending registers and selects the pending register for command reads. Its bit 1 set means no cascade word follows, and its bit 0 set means a mode word follows. The following data writes are consumed as base, then cascade word (if expected), then mode word (if expected).
- R3: Once initialised, a data write loads the mask and a data read returns it; mask bit n set blocks line n.
- R4: A rising edge on `ir_i[n]` sets pending bit n. The bit clears when the line falls before being acknowledged, or when the line is acknowledged.
- R5: `irq_o` is high exactly when some unmasked pending line has a lower index than every in-service line (or nothing is in service); line 0 ranks highest.
- R6: An accepted acknowledge sets the winner's in-service bit, clears its pending bit and presents a vector whose top five bits are the base's top five bits and whose low three bits are the line number.
- R7: `vec_valid`/`vec_data` hold steady until `vec_ready` is high at a clock edge; an acknowledge arriving while a vector waits changes nothing.
- R8: An acknowledge with no eligible line yields the vector base|7 and leaves the in-service register unchanged.
- R9: A command write with bits 4:3 = 01 and bit 1 set chooses what command reads return: bit 0 = 0 (0x0A) the pending register, bit 0 = 1 (0x0B) the in-service register.
- R10: Command 0x20 clears the lowest-index in-service bit; command 0x60|n clears in-service bit n.
- R11: In master role (`is_master` high), when the winning line has its cascade-word bit set, `cas_en_o` is high with `cas_id_o` equal to that line. The acknowledge then sets the master's in-service bit without a master vector. In slave role `cas_en_o` stays low.
- R12: In slave role the acknowledge is taken only when `cas_en_i` is high and `cas_id_i` equals the low three bits of the slave's cascade word; otherwise it is ignored.
- R13: End-of-interrupt on the slave leaves the master's in-service bit for the cascade line set until the master gets its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for the current address |
| ir_i | input | 8 | Request lines, rising-edge sensitive |
| irq_o | output | 1 | Interrupt request toward the processor or master |
| ack_i | input | 1 | Acknowledge strobe |
| vec_valid | output | 1 | Vector waiting |
| vec_ready | input | 1 | Consumer takes the vector |
| vec_data | output | 8 | Vector number |
| cas_en_o | output | 1 | Master: a slave must answer this acknowledge |
| cas_id_o | output | 3 | Master: identity of that slave |
| cas_en_i | input | 1 | Slave: cascade select from master |
| cas_id_i | input | 3 | Slave: identity selected by master |

## Verification
The properties assume that acknowledge and end-of-interrupt commands never arrive in the same cycle. They also assume that a non-specific end-of-interrupt is only counted against a non-empty in-service register, and that initialisation is not restarted while an acknowledge is in flight. The stimulus meets these assumptions by sequencing one register access, level change or acknowledge at a time from tasks, always at the falling clock edge. Random request levels and masks are held for several cycles, longer than the two-stage synchroniser plus edge register. The bench's transaction-level model can therefore treat each level change as settled before the next operation.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_RUN
  } init_st_e;

  localparam logic [2:0] OP_EOI_ANY = 3'b001;
  localparam logic [2:0] OP_EOI_ONE = 3'b011;
endpackage

// File: rtl/pic_regif.sv
module pic_regif
  import pic_pkg::*;
#(
  parameter int LINES = 8,
  parameter int DW    = 8,
  localparam int IDW  = $clog2(LINES),
  localparam int BW   = DW - IDW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [LINES-1:0] irr,
  input  logic [LINES-1:0] isr,
  output logic [DW-1:0]    bus_rdata,
  output logic [LINES-1:0] imr,
  output logic [BW-1:0]    vbase,
  output logic [LINES-1:0] casc,
  output logic             ready,
  output logic             init_clr,
  output logic             eoi_any,
  output logic             eoi_one,
  output logic [IDW-1:0]   eoi_lvl
);
  init_st_e st_q;
  logic     want_casc_q, want_mode_q, sel_isr_q;
  logic     cmd_wr, dat_wr;

  assign cmd_wr   = bus_wr && !bus_addr;
  assign dat_wr   = bus_wr && bus_addr;
  assign init_clr = cmd_wr && bus_wdata[4];
  assign eoi_any  = cmd_wr && !bus_wdata[4] && !bus_wdata[3] && bus_wdata[7:5] == OP_EOI_ANY;
  assign eoi_one  = cmd_wr && !bus_wdata[4] && !bus_wdata[3] && bus_wdata[7:5] == OP_EOI_ONE;
  assign eoi_lvl  = bus_wdata[IDW-1:0];
  assign ready    = (st_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_OFF;
      want_casc_q <= 1'b0;
      want_mode_q <= 1'b0;
      sel_isr_q   <= 1'b0;
      imr         <= '1;
      vbase       <= '0;
      casc        <= '0;
    end else if (init_clr) begin
      st_q        <= ST_BASE;
      want_casc_q <= !bus_wdata[1];
      want_mode_q <= bus_wdata[0];
      sel_isr_q   <= 1'b0;
      imr         <= '0;
      casc        <= '0;
    end else begin
      if (cmd_wr && bus_wdata[3] && bus_wdata[1])
        sel_isr_q <= bus_wdata[0];
      if (dat_wr) begin
        unique case (st_q)
          ST_BASE: begin
            vbase <= bus_wdata[DW-1:IDW];
            if (want_casc_q)      st_q <= ST_CASC;
            else if (want_mode_q) st_q <= ST_MODE;
            else                  st_q <= ST_RUN;
          end
          ST_CASC: begin
            casc <= bus_wdata[LINES-1:0];
            st_q <= want_mode_q ? ST_MODE : ST_RUN;
          end
          ST_MODE: st_q <= ST_RUN;
          default: imr <= bus_wdata[LINES-1:0];
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr)       bus_rdata[LINES-1:0] = imr;
    else if (sel_isr_q) bus_rdata[LINES-1:0] = isr;
    else                bus_rdata[LINES-1:0] = irr;
  end
endmodule

// File: rtl/pic_reqlatch.sv
module pic_reqlatch #(
  parameter int LINES = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [LINES-1:0] ir_i,
  input  logic [LINES-1:0] taken,
  output logic [LINES-1:0] irr
);
  logic [SYNC-1:0][LINES-1:0] stg_q;
  logic [LINES-1:0]           prev_q, lvl;

  assign lvl = stg_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= '0;
      irr    <= '0;
    end else begin
      stg_q[0] <= ir_i;
      for (int k = 1; k < SYNC; k++) stg_q[k] <= stg_q[k-1];
      prev_q <= lvl;
      if (clr) irr <= '0;
      else     irr <= lvl & (irr | ~prev_q) & ~taken;
    end
  end
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve #(
  parameter int LINES = 8,
  localparam int IDW  = $clog2(LINES)
) (
  input  logic [LINES-1:0] irr,
  input  logic [LINES-1:0] imr,
  input  logic [LINES-1:0] isr,
  output logic             win_ok,
  output logic [IDW-1:0]   win_idx
);
  logic [LINES-1:0] cand;
  logic [IDW:0]     ceil;
  logic             found;

  assign cand = irr & ~imr;

  always_comb begin
    ceil    = (IDW+1)'(LINES);
    found   = 1'b0;
    win_idx = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      if (isr[k]) ceil = (IDW+1)'(k);
      if (cand[k]) begin
        found   = 1'b1;
        win_idx = IDW'(k);
      end
    end
    win_ok = found && ({1'b0, win_idx} < ceil);
  end
endmodule

// File: rtl/pic_service.sv
module pic_service #(
  parameter int LINES = 8,
  parameter int DW    = 8,
  localparam int IDW  = $clog2(LINES),
  localparam int BW   = DW - IDW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_clr,
  input  logic             take,
  input  logic             win_ok,
  input  logic [IDW-1:0]   win_idx,
  input  logic             to_slave,
  input  logic [BW-1:0]    vbase,
  input  logic             eoi_any,
  input  logic             eoi_one,
  input  logic [IDW-1:0]   eoi_lvl,
  input  logic             vec_ready,
  output logic [LINES-1:0] isr,
  output logic [LINES-1:0] taken,
  output logic             vec_valid,
  output logic [DW-1:0]    vec_data
);
  logic [LINES-1:0] low_bit, drop, isr_n;

  always_comb begin
    taken   = '0;
    if (take && win_ok) taken[win_idx] = 1'b1;
    low_bit = isr & ~(isr - LINES'(1));
    drop    = '0;
    if (eoi_any) drop = drop | low_bit;
    if (eoi_one) drop[eoi_lvl] = 1'b1;
    isr_n   = (isr & ~drop) | taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr       <= '0;
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      isr <= init_clr ? '0 : isr_n;
      if (take && !(win_ok && to_slave)) begin
        vec_valid <= 1'b1;
        vec_data  <= {vbase, (win_ok ? win_idx : {IDW{1'b1}})};
      end else if (vec_ready) begin
        vec_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl #(
  parameter int LINES = 8,
  parameter int DW    = 8,
  parameter int SYNC  = 2,
  localparam int IDW  = $clog2(LINES),
  localparam int BW   = DW - IDW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_master,
  input  logic             bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [LINES-1:0] ir_i,
  output logic             irq_o,
  input  logic             ack_i,
  output logic             vec_valid,
  input  logic             vec_ready,
  output logic [DW-1:0]    vec_data,
  output logic             cas_en_o,
  output logic [IDW-1:0]   cas_id_o,
  input  logic             cas_en_i,
  input  logic [IDW-1:0]   cas_id_i
);
  logic [LINES-1:0] irr_w, isr_w, imr_w, casc_w, taken_w;
  logic [BW-1:0]    vbase_w;
  logic             ready_w, init_clr_w, eoi_any_w, eoi_one_w;
  logic [IDW-1:0]   eoi_lvl_w, win_idx_w;
  logic             win_ok_w, to_slave_w, ack_ok_w, take_w;

  pic_regif #(.LINES(LINES), .DW(DW)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .irr(irr_w), .isr(isr_w), .bus_rdata(bus_rdata),
    .imr(imr_w), .vbase(vbase_w), .casc(casc_w), .ready(ready_w),
    .init_clr(init_clr_w), .eoi_any(eoi_any_w), .eoi_one(eoi_one_w),
    .eoi_lvl(eoi_lvl_w)
  );

  pic_reqlatch #(.LINES(LINES), .SYNC(SYNC)) u_req (
    .clk(clk), .rst_n(rst_n), .clr(init_clr_w), .ir_i(ir_i),
    .taken(taken_w), .irr(irr_w)
  );

  pic_resolve #(.LINES(LINES)) u_res (
    .irr(irr_w), .imr(imr_w), .isr(isr_w), .win_ok(win_ok_w), .win_idx(win_idx_w)
  );

  assign to_slave_w = is_master && casc_w[win_idx_w];
  assign ack_ok_w   = is_master ? ack_i
                                : (ack_i && cas_en_i && cas_id_i == casc_w[IDW-1:0]);
  assign take_w     = ack_ok_w && ready_w && !vec_valid;
  assign irq_o      = ready_w && win_ok_w;
  assign cas_en_o   = irq_o && to_slave_w;
  assign cas_id_o   = cas_en_o ? win_idx_w : '0;

  pic_service #(.LINES(LINES), .DW(DW)) u_svc (
    .clk(clk), .rst_n(rst_n), .init_clr(init_clr_w), .take(take_w),
    .win_ok(win_ok_w), .win_idx(win_idx_w), .to_slave(to_slave_w),
    .vbase(vbase_w), .eoi_any(eoi_any_w), .eoi_one(eoi_one_w),
    .eoi_lvl(eoi_lvl_w), .vec_ready(vec_ready), .isr(isr_w),
    .taken(taken_w), .vec_valid(vec_valid), .vec_data(vec_data)
  );
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int LINES = 8,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             is_master,
  input logic             bus_addr,
  input logic             bus_wr,
  input logic [DW-1:0]    bus_wdata,
  input logic             ack_i,
  input logic             irq_o,
  input logic             vec_valid,
  input logic             vec_ready,
  input logic [DW-1:0]    vec_data,
  input logic             cas_en_o,
  input logic             ready,
  input logic [LINES-1:0] irr,
  input logic [LINES-1:0] imr,
  input logic [LINES-1:0] isr
);
  // R1: no request before initialisation completes
  p_quiet_uninit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !irq_o);

  // R5: nothing unmasked pending means no request
  p_masked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr & ~imr) == '0) |-> !irq_o);

  // R6: one acknowledge adds at most one in-service bit
  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr & ~$past(isr)) <= 1);

  // R7: waiting vector is held
  p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_data));

  // R7: acknowledge during a waiting vector leaves in-service alone
  p_pend_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && ack_i && !bus_wr |=> $stable(isr));

  // R8: master acknowledge without a request yields line 7 vector
  p_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready && is_master && ack_i && !vec_valid && !irq_o && !bus_wr
    |=> vec_valid && vec_data[2:0] == 3'b111);

  // R10: non-specific end-of-interrupt retires exactly one line
  p_eoi_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_addr && bus_wdata == 8'h20 && !ack_i && isr != '0
    |=> $countones(isr) == $countones($past(isr)) - 1);

  // R11: slave never drives the cascade select
  p_slave_no_cas_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> !cas_en_o);
endmodule

bind pic_ctrl pic_ctrl_chk #(.LINES(LINES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .ack_i(ack_i), .irq_o(irq_o),
  .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
  .cas_en_o(cas_en_o), .ready(ready_w), .irr(irr_w), .imr(imr_w), .isr(isr_w)
);

// File: tb/sim_pic_ctrl.sv
module sim_pic_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       bus_addr = 1'b0, wr0 = 1'b0, wr1 = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rd0, rd1, vd0, vd1;
  logic [7:0] lines_m = '0, lines_s = '0, ir0;
  logic       casc_mode = 1'b0;
  logic       ack = 1'b0, vrdy = 1'b0;
  logic       irq0, irq1, vv0, vv1, cen0, cen1;
  logic [2:0] cid0, cid1;

  int n_chk = 0, n_bad = 0;

  assign ir0 = casc_mode ? {lines_m[7:3], irq1, lines_m[1:0]} : lines_m;

  pic_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .is_master(1'b1), .bus_addr(bus_addr), .bus_wr(wr0),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .ir_i(ir0), .irq_o(irq0), .ack_i(ack),
    .vec_valid(vv0), .vec_ready(vrdy), .vec_data(vd0), .cas_en_o(cen0),
    .cas_id_o(cid0), .cas_en_i(1'b0), .cas_id_i(3'd0)
  );

  pic_ctrl u1 (
    .clk(clk), .rst_n(rst_n), .is_master(1'b0), .bus_addr(bus_addr), .bus_wr(wr1),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .ir_i(lines_s), .irq_o(irq1), .ack_i(ack),
    .vec_valid(vv1), .vec_ready(vrdy), .vec_data(vd1), .cas_en_o(cen1),
    .cas_id_o(cid1), .cas_en_i(cen0), .cas_id_i(cid0)
  );

  // bench model of the master
  logic [7:0] m_irr = '0, m_isr = '0, m_imr = '0, m_lvl = '0, m_base = 8'h20;

  function automatic int f_win(logic [7:0] irr, logic [7:0] imr, logic [7:0] isr);
    for (int i = 0; i < 8; i++) begin
      if (isr[i]) return 8;
      if (irr[i] && !imr[i]) return i;
    end
    return 8;
  endfunction

  function automatic logic [7:0] f_vec(logic [7:0] base, int w);
    return {base[7:3], (w < 8) ? 3'(w) : 3'd7};
  endfunction

  function automatic logic [7:0] f_lowclr(logic [7:0] isr);
    for (int i = 0; i < 8; i++) if (isr[i]) return isr & ~(8'd1 << i);
    return isr;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int chip, input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d;
    if (chip == 0) wr0 = 1'b1; else wr1 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rd(input int chip, input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = (chip == 0) ? rd0 : rd1;
  endtask

  task automatic get_irr(input int chip, output logic [7:0] d);
    wr(chip, 1'b0, 8'h0A); rd(chip, 1'b0, d);
  endtask

  task automatic get_isr(input int chip, output logic [7:0] d);
    wr(chip, 1'b0, 8'h0B); rd(chip, 1'b0, d);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_ready();
    @(negedge clk); vrdy = 1'b1;
    @(negedge clk); vrdy = 1'b0;
  endtask

  task automatic set_lines(input logic [7:0] l);
    @(negedge clk);
    lines_m = l;
    m_irr = (m_irr | (l & ~m_lvl)) & l;
    m_lvl = l;
    repeat (6) @(negedge clk);
  endtask

  task automatic compare_state(input string tag);
    logic [7:0] v;
    chk({tag, " R5 irq"}, int'(irq0), int'(f_win(m_irr, m_imr, m_isr) != 8));
    get_irr(0, v); chk({tag, " R4/R9 irr"}, v, m_irr);
    get_isr(0, v); chk({tag, " R9 isr"}, v, m_isr);
    rd(0, 1'b1, v); chk({tag, " R3 imr"}, v, m_imr);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", irq0, 0);
    chk("R1 vec_valid after reset", vv0, 0);
    rd(0, 1'b1, v); chk("R1 data read", v, 8'hFF);
    rd(0, 1'b0, v); chk("R1 cmd read", v, 8'h00);
    lines_m = 8'h01; repeat (6) @(negedge clk);
    chk("R1 no irq before init", irq0, 0);
    lines_m = 8'h00; repeat (6) @(negedge clk);

    // R2 initialisation, no slaves on master
    wr(0, 1'b0, 8'h11); wr(0, 1'b1, 8'h20); wr(0, 1'b1, 8'h00); wr(0, 1'b1, 8'h01);
    rd(0, 1'b1, v); chk("R2 mask cleared by init", v, 8'h00);
    get_irr(0, v); chk("R2 irr cleared", v, 8'h00);

    // R7 back-pressure, R6 grant, R10 end-of-interrupt
    set_lines(8'h02);
    pulse_ack();
    chk("R6 vec_valid", vv0, 1); chk("R6 vector line1", vd0, 8'h21);
    set_lines(8'h03);
    pulse_ack();
    chk("R7 vec held", vd0, 8'h21);
    get_isr(0, v); chk("R7 ack while pending ignored", v, 8'h02);
    pulse_ready();
    chk("R7 vec released", vv0, 0);
    pulse_ack(); chk("R6 vector line0", vd0, 8'h20); pulse_ready();
    get_isr(0, v); chk("R6 isr two lines", v, 8'h03);
    wr(0, 1'b0, 8'h20);
    get_isr(0, v); chk("R10 non-specific eoi", v, 8'h02);
    wr(0, 1'b0, 8'h61);
    get_isr(0, v); chk("R10 specific eoi", v, 8'h00);
    set_lines(8'h00);
    m_irr = '0; m_isr = '0;

    // R8 spurious: request withdrawn before acknowledge
    set_lines(8'h20);
    chk("R8 irq raised", irq0, 1);
    set_lines(8'h00);
    pulse_ack();
    chk("R8 spurious vector", vd0, 8'h27); pulse_ready();
    get_isr(0, v); chk("R8 isr untouched", v, 8'h00);

    // R3 mask
    wr(0, 1'b1, 8'hFF); m_imr = 8'hFF;
    set_lines(8'h10);
    chk("R3 masked line silent", irq0, 0);
    compare_state("R3 masked");

    // constrained random
    for (int it = 0; it < 80; it++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: set_lines(8'($urandom));
        1: begin
          logic [7:0] mk;
          mk = 8'($urandom & $urandom);
          wr(0, 1'b1, mk); m_imr = mk;
        end
        2: begin
          int w;
          w = f_win(m_irr, m_imr, m_isr);
          pulse_ack();
          chk("R6/R8 random vec_valid", vv0, 1);
          chk("R6/R8 random vector", vd0, f_vec(m_base, w));
          if (w < 8) begin m_isr[w] = 1'b1; m_irr[w] = 1'b0; end
          pulse_ready();
          chk("R7 random release", vv0, 0);
        end
        default: begin
          if (($urandom % 2) == 0) begin
            wr(0, 1'b0, 8'h20); m_isr = f_lowclr(m_isr);
          end else begin
            logic [2:0] n;
            n = 3'($urandom);
            wr(0, 1'b0, {5'b01100, n}); m_isr[n] = 1'b0;
          end
        end
      endcase
      compare_state("random");
    end

    // R2 single-chip sequence: base then mode word, no cascade word
    set_lines(8'h00);
    wr(0, 1'b0, 8'h13); wr(0, 1'b1, 8'h48); wr(0, 1'b1, 8'h01); wr(0, 1'b1, 8'hF0);
    m_irr = '0; m_isr = '0; m_imr = 8'hF0; m_base = 8'h48;
    rd(0, 1'b1, v); chk("R2 single mode mask", v, 8'hF0);
    set_lines(8'h02);
    pulse_ack(); chk("R2 single mode vector", vd0, 8'h49); pulse_ready();
    set_lines(8'h00);

    // R11..R13 cascade
    casc_mode = 1'b1; lines_m = 8'h00;
    wr(0, 1'b0, 8'h11); wr(0, 1'b1, 8'h20); wr(0, 1'b1, 8'h04); wr(0, 1'b1, 8'h01);
    wr(0, 1'b1, 8'hFB);
    wr(1, 1'b0, 8'h11); wr(1, 1'b1, 8'h28); wr(1, 1'b1, 8'h02); wr(1, 1'b1, 8'h01);
    wr(1, 1'b1, 8'h00);
    chk("R11 slave cas quiet", cen1, 0);
    @(negedge clk); lines_s = 8'h08;
    repeat (10) @(negedge clk);
    chk("R11 master irq", irq0, 1);
    chk("R11 cas_en", cen0, 1);
    chk("R11 cas_id", cid0, 2);
    pulse_ack();
    chk("R11 no master vector", vv0, 0);
    chk("R12 slave vector valid", vv1, 1);
    chk("R12 slave vector", vd1, 8'h2B);
    pulse_ready();
    get_isr(0, v); chk("R11 master isr", v, 8'h04);
    get_isr(1, v); chk("R12 slave isr", v, 8'h08);
    wr(1, 1'b0, 8'h20);
    get_isr(1, v); chk("R13 slave eoi", v, 8'h00);
    get_isr(0, v); chk("R13 master keeps cascade", v, 8'h04);
    wr(0, 1'b0, 8'h20);
    get_isr(0, v); chk("R13 master eoi", v, 8'h00);

    // R12 identity mismatch
    @(negedge clk); lines_s = 8'h00;
    repeat (10) @(negedge clk);
    wr(1, 1'b0, 8'h11); wr(1, 1'b1, 8'h28); wr(1, 1'b1, 8'h03); wr(1, 1'b1, 8'h01);
    wr(1, 1'b1, 8'h00);
    @(negedge clk); lines_s = 8'h08;
    repeat (10) @(negedge clk);
    chk("R12 mismatch master irq", irq0, 1);
    pulse_ack();
    chk("R12 mismatch no slave vector", vv1, 0);
    chk("R12 mismatch no master vector", vv0, 0);
    get_isr(1, v); chk("R12 mismatch slave isr", v, 8'h00);
    get_irr(1, v); chk("R12 mismatch slave irr kept", v, 8'h08);
    get_isr(0, v); chk("R11 mismatch master isr", v, 8'h04);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule